// File: doc/BRIEF.md
# Block-Erase Flash Memory Emulator

This block is a synthesizable stand-in for a flash-style non-volatile store. Any byte can be read through a byte-wide read port. A byte cannot simply be overwritten. Writes are made through a small register window: the host loads a target address and a data byte, then writes a command code. A program command can only clear bits in the stored byte. The only way to set bits back to one is an erase of the whole block that holds the address.

While a program or an erase runs, a busy bit in the status register stays high, and the host polls it to learn when the operation has finished. An erase holds the block busy for far more cycles than a byte program. For each block, a saturating counter records how many erases have completed. A sticky wear flag is raised when any block goes past a configured erase limit.

Every size and latency is a parameter: address width, block size, program and erase latency, wear limit and counter width.

Top module: `flash_emu`

## Requirements
- R1: After reset every byte reads 0xFF, the status register reads 0 and every erase counter reads 0.
- R2: When `rd_en_i` is high, `rd_data_o` shows the byte at `rd_addr_i` after the next rising clock edge, for any address outside the block under operation.
- R3: Command 0x01, written at register select 2, stores (old byte AND data register) at the address held in the address register. The new value can be read once busy has dropped.
- R4: If a program leaves the stored byte different from the data register, the error bit (status bit 1) is set. It stays set until a clear command.
- R5: Command 0x02 sets every byte of the block that contains the address register to 0xFF. Bytes in other blocks keep their values.
- R6: Status bit 0 (busy) is high for exactly PROG_LAT cycles after a program is accepted, and for exactly ERASE_LAT cycles after an erase is accepted. Status bit 3 is high while an erase runs.
- R7: A command written while busy is dropped. The running operation completes unchanged and the error bit is set.
- R8: A command value other than 0x01, 0x02 or 0x03 starts nothing and sets the error bit.
- R9: Command 0x03, written while idle, clears the error bit and the wear bit.
- R10: While an operation runs, a read to any address in its block returns the status byte. Reads to other blocks return stored data.
- R11: Each completed erase increments its block's counter, which saturates at its maximum. The counter for the block of the address register reads at register select 3.
- R12: The wear bit (status bit 2) is set when an erase completes and leaves its block's counter above WEAR_LIMIT.
- R13: Register select 0 holds the target address and select 1 holds the data byte. Both read back through `reg_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 8 | Read data, or the status byte while the addressed block is busy |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 address, 1 data, 2 command/status, 3 erase count |
| reg_wdata_i | input | REG_W | Register write value |
| reg_rdata_o | output | REG_W | Combinational read of the selected register |

## Verification
The assertions assume the host never starts an operation while one is running. The block guarantees this on its own by gating every start on the idle state. The bench still issues commands during busy on purpose, to exercise the reject path. The bench writes the register port at most once per cycle. It keeps every read request one cycle long, and it waits for busy to fall before it depends on the contents of the array. Each erase-count check is run only after the matching erase has finished.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_ERASE} op_state_e;

  localparam logic [7:0] CMD_PROG  = 8'h01;
  localparam logic [7:0] CMD_ERASE = 8'h02;
  localparam logic [7:0] CMD_CLEAR = 8'h03;

  localparam int STAT_BUSY  = 0;
  localparam int STAT_ERR   = 1;
  localparam int STAT_WEAR  = 2;
  localparam int STAT_ERASE = 3;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [1:0] SEL_WEAR = 2'd3;
endpackage

// File: rtl/flash_emu_array.sv
module flash_emu_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // power-up image is fully erased
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/flash_emu_ctrl.sv
module flash_emu_ctrl
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BLK_W     = 8,
  parameter int PROG_LAT  = 8,
  parameter int ERASE_LAT = 400,   // must be >= 2**BLK_W so the wipe walk completes
  localparam int NBLK_W   = ADDR_W - BLK_W,
  localparam int TMR_W    = $clog2(ERASE_LAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [7:0]        mem_old_i,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic              busy_o,
  output logic              erase_o,
  output logic              done_o,
  output logic              verify_fail_o,
  output logic [NBLK_W-1:0] blk_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o
);
  op_state_e         state_q;
  logic [TMR_W-1:0]  timer_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [BLK_W:0]    walk_q;
  logic [7:0]        prog_word;
  logic              last_cycle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      walk_q  <= '0;
    end else if (start_prog_i) begin
      state_q <= ST_PROG;
      timer_q <= TMR_W'(PROG_LAT - 1);
      addr_q  <= addr_i;
      data_q  <= data_i;
    end else if (start_erase_i) begin
      state_q <= ST_ERASE;
      timer_q <= TMR_W'(ERASE_LAT - 1);
      addr_q  <= addr_i;
      walk_q  <= '0;
    end else if (state_q != ST_IDLE) begin
      if (timer_q == '0) state_q <= ST_IDLE;
      else               timer_q <= timer_q - 1'b1;
      if (state_q == ST_ERASE && !walk_q[BLK_W]) walk_q <= walk_q + 1'b1;
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign erase_o    = state_q == ST_ERASE;
  assign last_cycle = busy_o && timer_q == '0;
  assign done_o     = last_cycle;
  assign blk_o      = addr_q[ADDR_W-1:BLK_W];
  assign tgt_addr_o = addr_q;

  // a program can only pull bits low
  assign prog_word     = mem_old_i & data_q;
  assign verify_fail_o = state_q == ST_PROG && last_cycle && prog_word != data_q;

  assign mem_we_o    = (state_q == ST_PROG && last_cycle) || (erase_o && !walk_q[BLK_W]);
  assign mem_waddr_o = erase_o ? {addr_q[ADDR_W-1:BLK_W], walk_q[BLK_W-1:0]} : addr_q;
  assign mem_wdata_o = erase_o ? 8'hFF : prog_word;

  p_we_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  p_start_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |-> !busy_o);
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_prog_i && !start_erase_i) |=> !busy_o);
endmodule

// File: rtl/flash_emu_wear.sv
module flash_emu_wear #(
  parameter int NBLK_W     = 2,
  parameter int CNT_W      = 8,
  parameter int WEAR_LIMIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic [NBLK_W-1:0] blk_i,
  input  logic [NBLK_W-1:0] qblk_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              over_o
);
  localparam int NBLK = 1 << NBLK_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(WEAR_LIMIT);

  logic [CNT_W-1:0] cnt_q [NBLK];
  logic [CNT_W-1:0] nxt;

  assign nxt = (cnt_q[blk_i] == CNT_MAX) ? CNT_MAX : cnt_q[blk_i] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBLK; b++) cnt_q[b] <= '0;
    end else if (inc_i) begin
      cnt_q[blk_i] <= nxt;
    end
  end

  assign cnt_o  = cnt_q[qblk_i];
  assign over_o = inc_i && nxt > LIM;

  for (genvar g = 0; g < NBLK; g++) begin : g_chk
    p_cnt_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[g] != $past(cnt_q[g])) |-> (cnt_q[g] - $past(cnt_q[g])) == CNT_W'(1));
  end
endmodule

// File: rtl/flash_emu.sv
module flash_emu
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int BLK_W      = 8,
  parameter int PROG_LAT   = 8,
  parameter int ERASE_LAT  = 400,
  parameter int WEAR_LIMIT = 2,
  parameter int CNT_W      = 8,
  parameter int REG_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  localparam int NBLK_W = ADDR_W - BLK_W;

  logic [ADDR_W-1:0] addr_q, tgt_addr, mem_waddr;
  logic [7:0]        data_q, rd_data_q, mem_old, mem_rd, mem_wdata, status;
  logic              err_q, wear_q;
  logic              busy, erase, done, verify_fail, mem_we, over;
  logic [NBLK_W-1:0] op_blk;
  logic [CNT_W-1:0]  wear_cnt;
  logic              cmd_wr, is_prog, is_erase, is_clear;
  logic              start_prog, start_erase, clear_cmd, cmd_bad;

  assign cmd_wr   = reg_we_i && reg_sel_i == SEL_CMD;
  assign is_prog  = reg_wdata_i == REG_W'(CMD_PROG);
  assign is_erase = reg_wdata_i == REG_W'(CMD_ERASE);
  assign is_clear = reg_wdata_i == REG_W'(CMD_CLEAR);

  assign start_prog  = cmd_wr && !busy && is_prog;
  assign start_erase = cmd_wr && !busy && is_erase;
  assign clear_cmd   = cmd_wr && !busy && is_clear;
  assign cmd_bad     = cmd_wr && (busy || !(is_prog || is_erase || is_clear));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
      wear_q <= 1'b0;
    end else begin
      if (reg_we_i && reg_sel_i == SEL_ADDR) addr_q <= reg_wdata_i[ADDR_W-1:0];
      if (reg_we_i && reg_sel_i == SEL_DATA) data_q <= reg_wdata_i[7:0];
      if (clear_cmd)                    err_q <= 1'b0;
      else if (cmd_bad || verify_fail)  err_q <= 1'b1;
      if (clear_cmd)                    wear_q <= 1'b0;
      else if (over)                    wear_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[STAT_BUSY]  = busy;
    status[STAT_ERR]   = err_q;
    status[STAT_WEAR]  = wear_q;
    status[STAT_ERASE] = erase;
  end

  // block under operation answers with status instead of data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= (busy && rd_addr_i[ADDR_W-1:BLK_W] == op_blk) ? status : mem_rd;
  end
  assign rd_data_o = rd_data_q;

  always_comb begin
    unique case (reg_sel_i)
      SEL_ADDR: reg_rdata_o = REG_W'(addr_q);
      SEL_DATA: reg_rdata_o = REG_W'(data_q);
      SEL_CMD:  reg_rdata_o = REG_W'(status);
      default:  reg_rdata_o = REG_W'(wear_cnt);
    endcase
  end

  flash_emu_ctrl #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .start_prog_i(start_prog), .start_erase_i(start_erase),
    .addr_i(addr_q), .data_i(data_q), .mem_old_i(mem_old),
    .tgt_addr_o(tgt_addr), .busy_o(busy), .erase_o(erase), .done_o(done),
    .verify_fail_o(verify_fail), .blk_o(op_blk),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  flash_emu_array #(.ADDR_W(ADDR_W), .DATA_W(8)) i_array (
    .clk_i, .rst_ni,
    .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_a_i(tgt_addr), .rdata_a_o(mem_old),
    .raddr_b_i(rd_addr_i), .rdata_b_o(mem_rd)
  );

  flash_emu_wear #(.NBLK_W(NBLK_W), .CNT_W(CNT_W), .WEAR_LIMIT(WEAR_LIMIT)) i_wear (
    .clk_i, .rst_ni,
    .inc_i(done && erase), .blk_i(op_blk), .qblk_i(addr_q[ADDR_W-1:BLK_W]),
    .cnt_o(wear_cnt), .over_o(over)
  );

  p_rd_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy && rd_addr_i[ADDR_W-1:BLK_W] == op_blk) |=> rd_data_o[STAT_BUSY]);
  p_err_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clear_cmd) |=> err_q);
  p_bad_sets_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_bad |=> err_q);
endmodule

// File: tb/test_flash_emu.sv
module test_flash_emu;
  localparam int ADDR_W = 10;
  localparam int REG_W  = 16;
  localparam int PLAT   = 8;
  localparam int ELAT   = 400;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_sel = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_emu i_flash_emu (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [15:0] val);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic rd_mem(input logic [ADDR_W-1:0] a, output logic [7:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] s;
    n = 0;
    rd_reg(2'd2, s);
    while (s[0]) begin
      n++;
      @(negedge clk);
      rd_reg(2'd2, s);
    end
  endtask

  task automatic program_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d, output int n);
    wr_reg(2'd0, 16'(a));
    wr_reg(2'd1, 16'(d));
    wr_reg(2'd2, 16'h0001);
    wait_idle(n);
  endtask

  task automatic t_reset;
    logic [7:0] v; logic [15:0] s;
    rd_mem(10'h000, v); chk("R1 byte 0x000", 16'(v), 16'h00FF);
    rd_mem(10'h3FF, v); chk("R1 byte 0x3FF", 16'(v), 16'h00FF);
    rd_reg(2'd2, s);    chk("R1 status", s, 16'h0000);
    rd_reg(2'd3, s);    chk("R1 erase count", s, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] s;
    wr_reg(2'd0, 16'h0123); rd_reg(2'd0, s); chk("R13 addr readback", s, 16'h0123);
    wr_reg(2'd1, 16'h00A5); rd_reg(2'd1, s); chk("R13 data readback", s, 16'h00A5);
  endtask

  task automatic t_program;
    logic [7:0] v; logic [15:0] s; int n;
    program_byte(10'h010, 8'h5A, n);
    chk("R6 program busy cycles", 16'(n), 16'(PLAT));
    rd_mem(10'h010, v); chk("R3 programmed byte", 16'(v), 16'h005A);
    rd_reg(2'd2, s);    chk("R3 no error on erased byte", s, 16'h0000);
    rd_mem(10'h011, v); chk("R2 neighbour untouched", 16'(v), 16'h00FF);
  endtask

  task automatic t_overprogram;
    logic [7:0] v; logic [15:0] s; int n;
    program_byte(10'h010, 8'hF0, n);
    rd_mem(10'h010, v); chk("R3 AND of old and new", 16'(v), 16'h0050);
    rd_reg(2'd2, s);    chk("R4 verify error bit", s, 16'h0002);
    wr_reg(2'd2, 16'h0003);
    rd_reg(2'd2, s);    chk("R9 clear error", s, 16'h0000);
  endtask

  task automatic t_busy_block;
    logic [7:0] v; logic [15:0] s; int n;
    wr_reg(2'd0, 16'h0020);
    wr_reg(2'd1, 16'h0011);
    wr_reg(2'd2, 16'h0001);
    rd_mem(10'h030, v); chk("R10 same block gives status", 16'(v), 16'h0001);
    rd_mem(10'h230, v); chk("R10 other block gives data", 16'(v), 16'h00FF);
    wr_reg(2'd2, 16'h0002);
    wait_idle(n);
    rd_reg(2'd2, s);    chk("R7 reject sets error", s, 16'h0002);
    rd_mem(10'h020, v); chk("R7 running program completes", 16'(v), 16'h0011);
    rd_mem(10'h030, v); chk("R7 rejected erase had no effect", 16'(v), 16'h00FF);
    rd_reg(2'd3, s);    chk("R7 no erase counted", s, 16'h0000);
    wr_reg(2'd2, 16'h0003);
  endtask

  task automatic t_erase;
    logic [7:0] v; logic [15:0] s; int n;
    program_byte(10'h150, 8'h33, n);
    program_byte(10'h250, 8'h44, n);
    rd_mem(10'h150, v); chk("R3 block1 byte programmed", 16'(v), 16'h0033);
    wr_reg(2'd0, 16'h0100);
    wr_reg(2'd2, 16'h0002);
    rd_reg(2'd2, s);    chk("R6 erase status bits", s, 16'h0009);
    wait_idle(n);
    chk("R6 erase busy cycles", 16'(n), 16'(ELAT));
    rd_mem(10'h150, v); chk("R5 erased byte", 16'(v), 16'h00FF);
    rd_mem(10'h1FF, v); chk("R5 last byte of block", 16'(v), 16'h00FF);
    rd_mem(10'h250, v); chk("R5 other block kept", 16'(v), 16'h0044);
    rd_reg(2'd3, s);    chk("R11 block1 count", s, 16'h0001);
  endtask

  task automatic t_invalid;
    logic [15:0] s;
    wr_reg(2'd2, 16'h0007);
    rd_reg(2'd2, s);    chk("R8 bad opcode error, idle", s, 16'h0002);
    wr_reg(2'd2, 16'h0003);
    rd_reg(2'd2, s);    chk("R9 clear after bad opcode", s, 16'h0000);
  endtask

  task automatic t_wear;
    logic [7:0] v; logic [15:0] s; int n;
    wr_reg(2'd0, 16'h0200);
    wr_reg(2'd2, 16'h0002);
    rd_mem(10'h210, v); chk("R10 erase block gives status", 16'(v), 16'h0009);
    rd_mem(10'h010, v); chk("R10 other block data in erase", 16'(v), 16'h0050);
    wait_idle(n);
    wr_reg(2'd2, 16'h0002); wait_idle(n);
    rd_reg(2'd2, s);    chk("R12 at limit no wear", s, 16'h0000);
    wr_reg(2'd2, 16'h0002); wait_idle(n);
    rd_reg(2'd2, s);    chk("R12 wear bit above limit", s, 16'h0004);
    rd_reg(2'd3, s);    chk("R11 block2 count", s, 16'h0003);
    rd_mem(10'h250, v); chk("R5 block2 erased", 16'(v), 16'h00FF);
    wr_reg(2'd2, 16'h0003);
    rd_reg(2'd2, s);    chk("R9 clear wear", s, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_program;
    t_overprogram;
    t_busy_block;
    t_erase;
    t_invalid;
    t_wear;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule